// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block turns three digital Hall sensor levels into six gate enables for a three-phase bipolar bridge. In each valid rotor position it selects one phase whose high-side switch sources current and another phase whose low-side switch sinks it. PWM chopping is applied to the high-side switches only. The selected low-side switch stays fully on for the whole commutation step.

Reverse rotation does not use a second table. The Hall code is inverted bit by bit and then passed through the forward table. When the run input is released, the bridge either coasts with every switch open, or brakes by closing all three high-side switches at full duty. A current-limit flag ends the high-side on-time for the rest of the current PWM period. A fault flag, from undervoltage or stall detection, opens only the chopped high side.

All six outputs come from registers, so a decoding glitch never reaches the gate drivers. The analog comparators, the PWM ramp oscillator, the current sense and the transistors all sit outside this block.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_rev_i`=0, the code `hall_i`={IN1,IN2,IN3} (bit 2 = IN1) selects the high side and low side as follows: 101 gives V high and U low; 100 gives W high and U low; 110 gives W high and V low; 010 gives U high and V low; 011 gives U high and W low; 001 gives V high and W low. Bit 0/1/2 of each output vector is phase U/V/W.
- R2: With `dir_rev_i`=1, the outputs are those that R1 gives for the bitwise-inverted code. For example, 010 gives V high and U low.
- R3: Outputs are registered and follow the inputs at the first rising clock edge after the inputs change. While `rst_n`=0, all six outputs are 0.
- R4: In run (`stop_i`=0), a high-side output is on only while `pwm_on_i`=1. The selected low-side output stays on whatever the value of `pwm_on_i`.
- R5: In run, `ilim_i`=1 turns the high side off from the next edge onward. It stays off for the rest of the PWM period, even after `ilim_i` drops. It turns on again at the first cycle in which `pwm_on_i` rises with `ilim_i`=0.
- R6: With `stop_i`=1 and `coast_sel_i`=0 (brake), all three high-side outputs are 1 and all low-side outputs are 0, whatever the values of `pwm_on_i` and `hall_i`.
- R7: With `stop_i`=1 and `coast_sel_i`=1 (coast), all six outputs are 0.
- R8: While braking, `ilim_i` has no effect on the outputs.
- R9: `fault_i`=1 forces all high-side outputs to 0, both in run and in brake. It leaves the low-side outputs as R1/R2 select them.
- R10: In run, the invalid codes 000 and 111 force all six outputs to 0.
- R11: The high-side and low-side outputs of the same phase are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Hall levels {IN1,IN2,IN3} |
| dir_rev_i | input | 1 | 0 forward, 1 reverse |
| stop_i | input | 1 | 0 run, 1 stop |
| coast_sel_i | input | 1 | Stop style: 0 brake, 1 coast |
| pwm_on_i | input | 1 | On-window of the PWM period |
| ilim_i | input | 1 | Current-limit flag |
| fault_i | input | 1 | Undervoltage or stall fault |
| hs_en_o | output | 3 | High-side enables, bit 0 U, 1 V, 2 W |
| ls_en_o | output | 3 | Low-side enables, bit 0 U, 1 V, 2 W |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench therefore drives its stimulus on a falling edge, lets one rising edge pass, and samples on the following falling edge. The current-limit hold is the one result that depends on history. It is checked over a run of such single-edge steps: the flag asserts, then drops while the window is still open, then the window closes and reopens. Each step has its own expected value.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int NPH = 3;
  typedef logic [NPH-1:0] phase_vec_t;

  typedef struct packed {
    logic       ok;
    phase_vec_t src;
    phase_vec_t snk;
  } step_t;

  // Apply direction: reverse rotation reuses the forward table on ~code.
  function automatic phase_vec_t hc_orient(input phase_vec_t code, input logic rev);
    return rev ? ~code : code;
  endfunction

  // Forward commutation lookup; bit0=U, bit1=V, bit2=W.
  function automatic step_t hc_lookup(input phase_vec_t code);
    step_t s;
    s = '0;
    s.ok = 1'b1;
    case (code)
      3'b101: begin s.src = 3'b010; s.snk = 3'b001; end
      3'b100: begin s.src = 3'b100; s.snk = 3'b001; end
      3'b110: begin s.src = 3'b100; s.snk = 3'b010; end
      3'b010: begin s.src = 3'b001; s.snk = 3'b010; end
      3'b011: begin s.src = 3'b001; s.snk = 3'b100; end
      3'b001: begin s.src = 3'b010; s.snk = 3'b100; end
      default: s.ok = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/hc_hall_decode.sv
module hc_hall_decode
  import hc_pkg::*;
(
  input  phase_vec_t hall_i,
  input  logic       rev_i,
  output step_t      step_o
);
  phase_vec_t code_w;
  assign code_w = hc_orient(hall_i, rev_i);
  assign step_o = hc_lookup(code_w);
endmodule

// File: rtl/hc_chop_gate.sv
module hc_chop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pwm_on_i,
  input  logic ilim_i,
  output logic gate_o
);
  logic pwm_prev_q;
  logic cut_q;
  logic pwm_rise_w;
  logic cut_hold_w;

  assign pwm_rise_w = pwm_on_i & ~pwm_prev_q;
  // A cut survives until the on-window reopens.
  assign cut_hold_w = cut_q & ~pwm_rise_w;
  assign gate_o     = pwm_on_i & ~cut_hold_w & ~ilim_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_prev_q <= 1'b0;
      cut_q      <= 1'b0;
    end else begin
      pwm_prev_q <= pwm_on_i;
      cut_q      <= cut_hold_w | (run_i & ilim_i);
    end
  end
endmodule

// File: rtl/hc_drive_mux.sv
module hc_drive_mux
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  step_t      step_i,
  input  logic       run_i,
  input  logic       coast_sel_i,
  input  logic       fault_i,
  input  logic       gate_i,
  output phase_vec_t hs_o,
  output phase_vec_t ls_o
);
  logic       brake_w;
  logic       drive_w;
  phase_vec_t hs_d;
  phase_vec_t ls_d;

  assign brake_w = ~run_i & ~coast_sel_i;
  assign drive_w = run_i & step_i.ok;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign hs_d[p] = ~fault_i & (brake_w | (drive_w & step_i.src[p] & gate_i));
    assign ls_d[p] = drive_w & step_i.snk[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= '0;
      ls_o <= '0;
    end else begin
      hs_o <= hs_d;
      ls_o <= ls_d;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       dir_rev_i,
  input  logic       stop_i,
  input  logic       coast_sel_i,
  input  logic       pwm_on_i,
  input  logic       ilim_i,
  input  logic       fault_i,
  output logic [2:0] hs_en_o,
  output logic [2:0] ls_en_o
);
  step_t step_w;
  logic  run_w;
  logic  gate_w;

  assign run_w = ~stop_i;

  hc_hall_decode i_dec (
    .hall_i (hall_i),
    .rev_i  (dir_rev_i),
    .step_o (step_w)
  );

  hc_chop_gate i_chop (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_w),
    .pwm_on_i (pwm_on_i),
    .ilim_i   (ilim_i),
    .gate_o   (gate_w)
  );

  hc_drive_mux i_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_w),
    .run_i       (run_w),
    .coast_sel_i (coast_sel_i),
    .fault_i     (fault_i),
    .gate_i      (gate_w),
    .hs_o        (hs_en_o),
    .ls_o        (ls_en_o)
  );
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall_i,
  input logic       stop_i,
  input logic       coast_sel_i,
  input logic       ilim_i,
  input logic       fault_i,
  input logic       gate_w,
  input logic [2:0] hs_en_o,
  input logic [2:0] ls_en_o
);
  // R11
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en_o & ls_en_o) == 3'b000);
  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && !gate_w) |=> hs_en_o == 3'b000);
  // R1
  one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ls_en_o));
  // R6
  brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !coast_sel_i && !fault_i) |=> (hs_en_o == 3'b111 && ls_en_o == 3'b000));
  // R7
  coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && coast_sel_i) |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));
  // R9
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> hs_en_o == 3'b000);
  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && (hall_i == 3'b000 || hall_i == 3'b111)) |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));
  // R5
  ilim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && ilim_i) |=> hs_en_o == 3'b000);
endmodule

bind hall_commutator hall_commutator_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hall_i      (hall_i),
  .stop_i      (stop_i),
  .coast_sel_i (coast_sel_i),
  .ilim_i      (ilim_i),
  .fault_i     (fault_i),
  .gate_w      (gate_w),
  .hs_en_o     (hs_en_o),
  .ls_en_o     (ls_en_o)
);

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_i = 3'b101;
  logic dir_rev_i = 1'b0, stop_i = 1'b1, coast_sel_i = 1'b1;
  logic pwm_on_i = 1'b0, ilim_i = 1'b0, fault_i = 1'b0;
  logic [2:0] hs_en_o, ls_en_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_commutator i_hall_commutator (
    .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_rev_i(dir_rev_i),
    .stop_i(stop_i), .coast_sel_i(coast_sel_i), .pwm_on_i(pwm_on_i),
    .ilim_i(ilim_i), .fault_i(fault_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

  // Expected forward step written as (high phase, low phase) letters U=0 V=1 W=2.
  function automatic void fwd_ref(input logic [2:0] c, output int hi, output int lo);
    hi = -1; lo = -1;
    if (c == 3'b101) begin hi = 1; lo = 0; end
    if (c == 3'b100) begin hi = 2; lo = 0; end
    if (c == 3'b110) begin hi = 2; lo = 1; end
    if (c == 3'b010) begin hi = 0; lo = 1; end
    if (c == 3'b011) begin hi = 0; lo = 2; end
    if (c == 3'b001) begin hi = 1; lo = 2; end
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] hs_x, input logic [2:0] ls_x);
    checks++;
    if (hs_en_o !== hs_x || ls_en_o !== ls_x) begin
      errors++;
      $display("FAIL %s hs=%b ls=%b expected hs=%b ls=%b", req, hs_en_o, ls_en_o, hs_x, ls_x);
    end
  endtask

  task automatic run_mode();
    stop_i = 1'b0; pwm_on_i = 1'b1; ilim_i = 1'b0; fault_i = 1'b0;
  endtask

  task automatic t_reset();
    // R3: outputs low in reset even though brake inputs are applied
    coast_sel_i = 1'b0; stop_i = 1'b1;
    step();
    chk("R3 reset", 3'b000, 3'b000);
    rst_n = 1'b1;
    coast_sel_i = 1'b1;
    step();
    chk("R3 after reset coast", 3'b000, 3'b000);
  endtask

  task automatic t_direction(input logic rev);
    run_mode();
    dir_rev_i = rev;
    for (int c = 1; c < 7; c++) begin
      int hi, lo;
      hall_i = 3'(c);
      fwd_ref(rev ? ~hall_i : hall_i, hi, lo);
      step();
      chk(rev ? "R2 reverse" : "R1 forward", 3'(1 << hi), 3'(1 << lo));
    end
    dir_rev_i = 1'b0;
  endtask

  task automatic t_latency();
    // R3: new code visible one edge later, not before
    run_mode();
    hall_i = 3'b101; step();
    @(posedge clk); #1;
    hall_i = 3'b010;
    #1 chk("R3 hold until edge", 3'b010, 3'b001);
    @(negedge clk);
    step();
    chk("R3 update", 3'b001, 3'b010);
  endtask

  task automatic t_pwm_gate();
    run_mode();
    hall_i = 3'b011;
    pwm_on_i = 1'b0; step();
    chk("R4 window closed", 3'b000, 3'b100);
    pwm_on_i = 1'b1; step();
    chk("R4 window open", 3'b001, 3'b100);
  endtask

  task automatic t_ilim();
    run_mode();
    hall_i = 3'b110; step();
    chk("R5 before limit", 3'b100, 3'b010);
    ilim_i = 1'b1; step();
    chk("R5 limit hit", 3'b000, 3'b010);
    ilim_i = 1'b0; step();
    chk("R5 held rest of period", 3'b000, 3'b010);
    pwm_on_i = 1'b0; step();
    chk("R5 window closed", 3'b000, 3'b010);
    pwm_on_i = 1'b1; step();
    chk("R5 re-enabled at new window", 3'b100, 3'b010);
  endtask

  task automatic t_brake();
    stop_i = 1'b1; coast_sel_i = 1'b0; pwm_on_i = 1'b0; hall_i = 3'b111;
    step();
    chk("R6 brake", 3'b111, 3'b000);
    // R8: limit flag ignored while braking
    ilim_i = 1'b1; step();
    chk("R8 brake with limit", 3'b111, 3'b000);
    ilim_i = 1'b0; step();
    chk("R8 brake after limit", 3'b111, 3'b000);
    fault_i = 1'b1; step();
    chk("R9 fault during brake", 3'b000, 3'b000);
    fault_i = 1'b0;
  endtask

  task automatic t_coast();
    stop_i = 1'b1; coast_sel_i = 1'b1; pwm_on_i = 1'b1; hall_i = 3'b100;
    step();
    chk("R7 coast", 3'b000, 3'b000);
  endtask

  task automatic t_fault();
    run_mode();
    hall_i = 3'b001; fault_i = 1'b1; step();
    chk("R9 fault run", 3'b000, 3'b100);
    fault_i = 1'b0; step();
    chk("R9 fault cleared", 3'b010, 3'b100);
  endtask

  task automatic t_invalid();
    run_mode();
    hall_i = 3'b000; step();
    chk("R10 code 000", 3'b000, 3'b000);
    hall_i = 3'b111; dir_rev_i = 1'b1; step();
    chk("R10 code 111 reverse", 3'b000, 3'b000);
    dir_rev_i = 1'b0;
  endtask

  task automatic t_no_overlap();
    // R11: same-phase pair never both on across a sweep
    run_mode();
    for (int c = 0; c < 16; c++) begin
      hall_i = 3'(c); dir_rev_i = c[3];
      step();
      checks++;
      if ((hs_en_o & ls_en_o) != 3'b000) begin
        errors++;
        $display("FAIL R11 hs=%b ls=%b expected no overlap", hs_en_o, ls_en_o);
      end
    end
    dir_rev_i = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_direction(1'b0);
    t_direction(1'b1);
    t_latency();
    t_pwm_gate();
    t_ilim();
    t_brake();
    t_coast();
    t_fault();
    t_invalid();
    t_no_overlap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule